// File: doc/BRIEF.md
# DLL Sampling Phase Sequencer

This block steers a delay-locked loop onto a new output-clock sampling phase. A single-cycle start request carries a 4-bit phase index. The block then walks the DLL control word through a fixed handshake. First it parks the clock-recovery loop on an external phase selection and turns the clock output off. It waits until the DLL reports the output as off. Next it writes the phase, encoded in reflected binary Gray code, and turns the clock output back on. It waits until the DLL reports the output as on. Finally it returns control to the clock-recovery loop.

Each of the two waits is a polled check paced by a 1 µs tick input. A wait gives up after a bounded number of polls. When it gives up, the sequence aborts with a one-cycle error pulse. A clean finish produces a one-cycle done pulse. The 32-bit control word is the block's output and feeds the DLL directly. The DLL status bit comes straight back as an input.

Top module: `dll_phase_seq`

## Requirements
- R1: After reset the control word is all zeros, and busy, done and error are all low.
- R2: The first update after an accepted start does all of the following in one clock: it sets DLL enable (bit 16) and external select (bit 19), and it clears recovery enable (bit 17) and clock-output enable (bit 18). The rest of the word is left unchanged. The update is visible in the second cycle after the start cycle.
- R3: Polls in the first wait happen only on cycles with the tick high. The sequence leaves the first wait only on a tick where the status input is 0. With no ticks, the block stays busy and the control word does not change.
- R4: The phase index b is written to bits 23:20 as the reflected Gray code b ^ (b >> 1). This gives the order 0,1,3,2,6,7,5,4,12,13,15,14,10,11,9,8 for b = 0..15.
- R5: After the phase field is written, clock-output enable (bit 18) is set. The second wait then advances only on a tick where the status input is 1.
- R6: The final update sets bit 17 and clears bit 19. The done pulse is high in the same cycle that this final word first appears, and busy is low in that cycle.
- R7: If a wait sees POLL_LIMIT consecutive polls with the wrong status (default 50), the sequence aborts and pulses error. It does not write the final update. The control word keeps the last values driven. With POLL_LIMIT-1 failing polls followed by a good poll, the sequence succeeds.
- R8: The phase index is captured in the start cycle. A start that arrives while the block is busy is ignored. It changes neither the written phase nor the number of completion pulses.
- R9: Done and error each last exactly one cycle, and they are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startPulse | input | 1 | Begin a phase change (acted on only when idle) |
| phaseIdx | input | 4 | Requested phase index, captured at start |
| usTick | input | 1 | One-cycle pulse every microsecond; paces the polls |
| ckOutStatus | input | 1 | Clock-output-enable state reported by the DLL |
| cfgWord | output | 32 | DLL control word |
| busy | output | 1 | Sequence in progress |
| donePulse | output | 1 | One-cycle pulse on successful completion |
| errPulse | output | 1 | One-cycle pulse on a wait timeout |

## Verification
The bench keeps the default POLL_LIMIT of 50, a 32-bit word and a 4-bit phase, and it raises the tick every fourth clock. With those values, even a full 50-poll timeout takes only a few hundred cycles. That makes it cheap to probe the exact limit edge in both waits: 49 failing polls must succeed and 50 must abort. It also leaves room for dozens of randomized phase changes with random DLL answer delays. The DLL stand-in holds its status wrong for a chosen number of ticks in each wait. That fixes the number of failing polls exactly, so the expected outcome and the expected final control word follow directly from the requirements.

// File: rtl/dps_pkg.sv
package dps_pkg;

  // Control word bit positions decoded by the DLL
  localparam int DLL_EN_BIT   = 16;
  localparam int CDR_EN_BIT   = 17;
  localparam int CK_OUT_BIT   = 18;
  localparam int EXT_SEL_BIT  = 19;
  localparam int PHASE_LSB    = 20;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PREP,
    ST_WAIT_OFF,
    ST_PHASE,
    ST_CK_ON,
    ST_WAIT_ON,
    ST_FINISH
  } seqState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic prep;
    logic phaseWr;
    logic ckOn;
    logic finish;
    logic pollClr;
    logic pollInc;
  } dpStrobe_t;

endpackage

// File: rtl/dps_datapath.sv
module dps_datapath
  import dps_pkg::*;
#(
  parameter int CFG_W      = 32,
  parameter int PHASE_W    = 4,
  parameter int POLL_LIMIT = 50
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          strobe,
  input  logic [PHASE_W-1:0] phaseIn,
  output logic [CFG_W-1:0]   cfgWord,
  output logic               pollLast
);

  localparam int POLL_W = (POLL_LIMIT > 2) ? $clog2(POLL_LIMIT) : 1;
  localparam logic [POLL_W-1:0] POLL_END = POLL_W'(POLL_LIMIT - 1);

  logic [PHASE_W-1:0] phaseHeld;
  logic [PHASE_W-1:0] grayCode;
  logic [CFG_W-1:0]   cfgReg;
  logic [POLL_W-1:0]  pollCnt;

  // Reflected binary Gray encoding of the held phase
  for (genvar i = 0; i < PHASE_W; i++) begin : g_gray
    if (i == PHASE_W - 1) begin : g_top
      assign grayCode[i] = phaseHeld[i];
    end else begin : g_mid
      assign grayCode[i] = phaseHeld[i] ^ phaseHeld[i+1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseHeld <= '0;
    end else if (strobe.capture) begin
      phaseHeld <= phaseIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg <= '0;
    end else begin
      if (strobe.prep) begin
        cfgReg[DLL_EN_BIT]  <= 1'b1;
        cfgReg[EXT_SEL_BIT] <= 1'b1;
        cfgReg[CDR_EN_BIT]  <= 1'b0;
        cfgReg[CK_OUT_BIT]  <= 1'b0;
      end
      if (strobe.phaseWr) begin
        cfgReg[PHASE_LSB +: PHASE_W] <= grayCode;
      end
      if (strobe.ckOn) begin
        cfgReg[CK_OUT_BIT] <= 1'b1;
      end
      if (strobe.finish) begin
        cfgReg[CDR_EN_BIT]  <= 1'b1;
        cfgReg[EXT_SEL_BIT] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pollCnt <= '0;
    end else if (strobe.pollClr) begin
      pollCnt <= '0;
    end else if (strobe.pollInc) begin
      pollCnt <= pollCnt + 1'b1;
    end
  end

  assign pollLast = (pollCnt == POLL_END);
  assign cfgWord  = cfgReg;

  // The failing-poll count never passes the last allowed poll
  assert_poll_bound_R7: assert property (@(posedge clk) disable iff (!rstN)
    pollCnt <= POLL_END);

endmodule

// File: rtl/dps_ctrl.sv
module dps_ctrl
  import dps_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startPulse,
  input  logic      usTick,
  input  logic      ckOutStatus,
  input  logic      pollLast,
  output dpStrobe_t strobe,
  output logic      busy,
  output logic      donePulse,
  output logic      errPulse
);

  seqState_t state, nextState;
  logic doneSet, errSet;

  always_comb begin
    nextState = state;
    strobe    = '0;
    doneSet   = 1'b0;
    errSet    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (startPulse) begin
          strobe.capture = 1'b1;
          strobe.pollClr = 1'b1;
          nextState      = ST_PREP;
        end
      end
      ST_PREP: begin
        strobe.prep = 1'b1;
        nextState   = ST_WAIT_OFF;
      end
      ST_WAIT_OFF: begin
        if (usTick) begin
          if (!ckOutStatus) begin
            nextState = ST_PHASE;
          end else if (pollLast) begin
            errSet    = 1'b1;
            nextState = ST_IDLE;
          end else begin
            strobe.pollInc = 1'b1;
          end
        end
      end
      ST_PHASE: begin
        strobe.phaseWr = 1'b1;
        nextState      = ST_CK_ON;
      end
      ST_CK_ON: begin
        strobe.ckOn    = 1'b1;
        strobe.pollClr = 1'b1;
        nextState      = ST_WAIT_ON;
      end
      ST_WAIT_ON: begin
        if (usTick) begin
          if (ckOutStatus) begin
            nextState = ST_FINISH;
          end else if (pollLast) begin
            errSet    = 1'b1;
            nextState = ST_IDLE;
          end else begin
            strobe.pollInc = 1'b1;
          end
        end
      end
      ST_FINISH: begin
        strobe.finish = 1'b1;
        doneSet       = 1'b1;
        nextState     = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      donePulse <= 1'b0;
      errPulse  <= 1'b0;
    end else begin
      state     <= nextState;
      donePulse <= doneSet;
      errPulse  <= errSet;
    end
  end

  assign busy = (state != ST_IDLE);

  assert_done_err_excl_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(donePulse && errPulse));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);

  assert_err_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |=> !errPulse);

  // A start seen while busy never ends the sequence on the next edge by itself
  assert_busy_start_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startPulse && state == ST_PREP) |=> busy);

endmodule

// File: rtl/dll_phase_seq.sv
module dll_phase_seq
  import dps_pkg::*;
#(
  parameter int CFG_W      = 32,
  parameter int PHASE_W    = 4,
  parameter int POLL_LIMIT = 50
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startPulse,
  input  logic [PHASE_W-1:0] phaseIdx,
  input  logic               usTick,
  input  logic               ckOutStatus,
  output logic [CFG_W-1:0]   cfgWord,
  output logic               busy,
  output logic               donePulse,
  output logic               errPulse
);

  dpStrobe_t strobe;
  logic      pollLast;

  dps_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .usTick     (usTick),
    .ckOutStatus(ckOutStatus),
    .pollLast   (pollLast),
    .strobe     (strobe),
    .busy       (busy),
    .donePulse  (donePulse),
    .errPulse   (errPulse)
  );

  dps_datapath #(
    .CFG_W     (CFG_W),
    .PHASE_W   (PHASE_W),
    .POLL_LIMIT(POLL_LIMIT)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .phaseIn (phaseIdx),
    .cfgWord (cfgWord),
    .pollLast(pollLast)
  );

  // On completion the DLL is back under recovery control with output on
  assert_final_bits_R6: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> (cfgWord[DLL_EN_BIT] && cfgWord[CDR_EN_BIT] &&
                   cfgWord[CK_OUT_BIT] && !cfgWord[EXT_SEL_BIT]));

  // An abort leaves the word parked on external selection
  assert_abort_bits_R7: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> (cfgWord[DLL_EN_BIT] && cfgWord[EXT_SEL_BIT] &&
                  !cfgWord[CDR_EN_BIT]));

endmodule

// File: tb/dll_phase_seq_tb.sv
module dll_phase_seq_tb;

  localparam int LIMIT = 50;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startPulse = 1'b0;
  logic [3:0]  phaseIdx = '0;
  logic        usTick = 1'b0;
  logic        ckOutStatus;
  logic [31:0] cfgWord;
  logic        busy, donePulse, errPulse;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  logic       tickEn = 1'b1;
  logic [1:0] tickDiv = '0;
  int kLow = 0, kHigh = 0;
  int cntLow = 0, cntHigh = 0;
  logic [31:0] expCfg = '0;

  const logic [3:0] GRAY_TAB [16] = '{4'd0, 4'd1, 4'd3, 4'd2, 4'd6, 4'd7, 4'd5, 4'd4,
                                      4'd12, 4'd13, 4'd15, 4'd14, 4'd10, 4'd11, 4'd9, 4'd8};

  always #10 clk = ~clk;

  dll_phase_seq u_dut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .phaseIdx(phaseIdx),
    .usTick(usTick), .ckOutStatus(ckOutStatus), .cfgWord(cfgWord),
    .busy(busy), .donePulse(donePulse), .errPulse(errPulse)
  );

  // Tick every fourth clock
  always @(posedge clk) begin
    tickDiv <= tickDiv + 2'd1;
    usTick  <= tickEn && (tickDiv == 2'd2);
  end

  // DLL stand-in: status stays wrong for kLow / kHigh ticks inside each wait window
  wire inLow  = cfgWord[19] && !cfgWord[18];
  wire inHigh = cfgWord[19] &&  cfgWord[18];
  always_comb begin
    if (inLow)       ckOutStatus = (cntLow  >= kLow)  ? 1'b0 : 1'b1;
    else if (inHigh) ckOutStatus = (cntHigh >= kHigh) ? 1'b1 : 1'b0;
    else             ckOutStatus = cfgWord[18];
  end
  always @(posedge clk) begin
    if (startPulse || !inLow) cntLow <= 0;
    else if (usTick && cntLow < kLow) cntLow <= cntLow + 1;
    if (startPulse || !inHigh) cntHigh <= 0;
    else if (usTick && cntHigh < kHigh) cntHigh <= cntHigh + 1;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] prepOf(input logic [31:0] c);
    logic [31:0] r = c;
    r[16] = 1'b1; r[19] = 1'b1; r[17] = 1'b0; r[18] = 1'b0;
    return r;
  endfunction

  // mode: 0 plain, 1 second start while busy, 2 ticks held off at start
  task automatic runOp(input logic [3:0] ph, input int kl, input int kh, input int mode);
    logic [31:0] expPrep, expEnd;
    bit okExp, sawDone, sawErr;
    kLow = kl; kHigh = kh;
    if (mode == 2) tickEn = 1'b0;
    @(negedge clk); startPulse = 1'b1; phaseIdx = ph;
    @(negedge clk); startPulse = 1'b0; phaseIdx = ~ph;
    @(negedge clk);
    expPrep = prepOf(expCfg);
    check(cfgWord == expPrep && busy, "R2 prep word", cfgWord, expPrep);
    if (mode == 1) begin
      startPulse = 1'b1; phaseIdx = ph + 4'd5;
      @(negedge clk); startPulse = 1'b0;
    end
    if (mode == 2) begin
      repeat (30) @(negedge clk);
      check(cfgWord == expPrep && busy, "R3 no tick no advance", cfgWord, expPrep);
      tickEn = 1'b1;
    end
    for (int n = 0; n < 3000; n++) begin
      if (donePulse || errPulse) break;
      @(negedge clk);
    end
    okExp = (kl < LIMIT) && (kh < LIMIT);
    if (okExp) begin
      expEnd = expPrep;
      expEnd[23:20] = GRAY_TAB[ph];
      expEnd[18] = 1'b1; expEnd[17] = 1'b1; expEnd[19] = 1'b0;
    end else if (kl >= LIMIT) begin
      expEnd = expPrep;
    end else begin
      expEnd = expPrep;
      expEnd[23:20] = GRAY_TAB[ph];
      expEnd[18] = 1'b1;
    end
    sawDone = donePulse; sawErr = errPulse;
    check(sawDone == okExp && sawErr == !okExp, okExp ? "R6 done on success" : "R7 error on timeout",
          {30'd0, sawDone, sawErr}, {30'd0, okExp, !okExp});
    check(!(sawDone && sawErr), "R9 exclusive pulses", {31'd0, sawDone && sawErr}, 32'd0);
    check(!busy, "R6 R7 idle at end", {31'd0, busy}, 32'd0);
    check(cfgWord == expEnd, okExp ? "R4 R5 R6 final word" : "R7 word kept on abort",
          cfgWord, expEnd);
    @(negedge clk);
    check(!donePulse && !errPulse, "R9 one-cycle pulse", {30'd0, donePulse, errPulse}, 32'd0);
    if (mode == 1) begin
      repeat (20) @(negedge clk);
      check(!busy && !donePulse, "R8 ignored start left no work", {30'd0, busy, donePulse}, 32'd0);
    end
    expCfg = expEnd;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(cfgWord == 32'd0, "R1 reset word", cfgWord, 32'd0);
    check(!busy && !donePulse && !errPulse, "R1 reset flags",
          {29'd0, busy, donePulse, errPulse}, 32'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R4: every phase index through the Gray map
    for (int p = 0; p < 16; p++) runOp(4'(p), 0, 0, 0);
    // R3 / R5: delayed status answers
    runOp(4'd6, 7, 0, 0);
    runOp(4'd9, 0, 11, 0);
    // R7: poll-limit edges in each wait
    runOp(4'd3, LIMIT - 1, 0, 0);
    runOp(4'd4, LIMIT, 0, 0);
    runOp(4'd5, 0, LIMIT - 1, 0);
    runOp(4'd10, 0, LIMIT, 0);
    runOp(4'd12, 2, 2, 0);
    // R8: start while busy
    runOp(4'd13, 3, 3, 1);
    // R3: ticks held off
    runOp(4'd14, 0, 0, 2);

    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < 40; i++) begin
      int kl = ($urandom % 8 == 0) ? LIMIT + int'($urandom % 5) : int'($urandom % 20);
      int kh = ($urandom % 8 == 0) ? LIMIT + int'($urandom % 5) : int'($urandom % 20);
      runOp(4'($urandom), kl, kh, ($urandom % 6 == 0) ? 1 : 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule